// File: doc/BRIEF.md
# Dual-Slope PWM Timer/Counter

This block is an up/down timer/counter that produces symmetric, phase-correct pulse-width modulation on two compare channels, A and B. A prescaler turns the system clock into a count-enable tick, divided by 1, 8, 64, 256 or 1024 as chosen by a clock-select code. On each tick the counter climbs from zero to its top value and then falls back to zero. One waveform period therefore lasts 2*MAX ticks, which is 510 ticks at the default 8-bit width.

Each channel compares the count against its own compare value. The compare value is double-buffered and takes effect when the counter reaches its top. A per-channel output mode selects a disconnected pin, a normal PWM wave, an inverted PWM wave, or (on channel A only, when the toggle enable is set) a wave that toggles on every match. The PWM level is forced at the top of the count, so the wave stays symmetric around zero even when a match is skipped or the compare value leaves the top value. Sticky flags record counter underflow to zero and compare matches. Each flag is cleared by a one-cycle strobe.

Top module: `pwm_dual_slope_timer`

## Requirements
- R1: While reset is high, and on the first cycle after it, both waveform pins and all three flags are 0. Reset also sets the count to 0, the direction to up, the compare buffers to 0 and the prescaler divider to 0.
- R2: clk_sel codes 1, 2, 3, 4 and 5 give one count tick every 1, 8, 64, 256 and 1024 clocks. Codes 0, 6 and 7 stop the counter and clear the divider. With code 2 held from reset, the first tick is on the 8th clock edge after reset is released.
- R3: On each tick the count steps 0,1,...,MAX,MAX-1,...,1,0,1,..., so a full period is 2*MAX ticks. ovf_flag is set on the tick on which the count becomes 0. With CNT_W=4 and code 2 held from reset, ovf_flag first reads 1 after the 240th clock edge.
- R4: The PWM level of a channel becomes 0 when the count reaches the compare value while climbing, and becomes 1 when the count reaches it while falling. Mode 2'b10 drives the level to the pin and mode 2'b11 drives its inverse. The pin is registered, so it shows the level one clock after the level changes.
- R5: A compare value of 0 keeps the level at 0 for the whole period. A compare value of MAX keeps the level at 1 for the whole period.
- R6: When the count reaches MAX and the compare value is not MAX, the level is forced to 0 (the climbing-match level), whether or not a match occurred. This gives a transition with no match when the compare value moves away from MAX.
- R7: cmp_a and cmp_b are sampled into the active compare value on the tick on which the count reaches MAX. A change at any other time has no effect until then.
- R8: With mode 2'b01 and tog_en_a high, wave_a shows a toggle register that flips on every tick on which the count reaches the compare value of channel A. With mode 2'b01, channel B, or channel A with tog_en_a low, drives the pin to 0.
- R9: Mode 2'b00 drives the pin to 0.
- R10: match_a_flag and match_b_flag are set on each tick on which the count reaches the channel's compare value, in any output mode. They hold until a clear strobe (clr_match_a, clr_match_b) is seen on a clock with no new match. When a set and a clear land on the same clock, the set wins. ovf_flag follows the same rule with clr_ovf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Prescale select: 0 stop, 1 /1, 2 /8, 3 /64, 4 /256, 5 /1024, 6-7 stop |
| cmp_a | input | CNT_W | Compare value for channel A (buffered at MAX) |
| cmp_b | input | CNT_W | Compare value for channel B (buffered at MAX) |
| mode_a | input | 2 | Channel A output mode: 00 off, 01 toggle, 10 normal, 11 inverted |
| mode_b | input | 2 | Channel B output mode: 00 off, 01 off, 10 normal, 11 inverted |
| tog_en_a | input | 1 | Enables toggle-on-match for channel A |
| clr_ovf | input | 1 | Clear strobe for ovf_flag |
| clr_match_a | input | 1 | Clear strobe for match_a_flag |
| clr_match_b | input | 1 | Clear strobe for match_b_flag |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| ovf_flag | output | 1 | Sticky flag, set when the count reaches zero |
| match_a_flag | output | 1 | Sticky compare-match flag, channel A |
| match_b_flag | output | 1 | Sticky compare-match flag, channel B |

## Verification
The bench builds the timer with CNT_W=4 and PRE_W=10. This shortens a period to 30 ticks and keeps every prescale factor available. With these values, every compare value from 0 to 15 can be swept on both channels in every output mode, and a full period at the /1024 setting fits in about 31k clocks. The expected pins and flags come from an arithmetic model of the requirements, compared on every clock. The random phase moves compare values in the middle of a period and drives clear strobes, which covers the forced level at the top, the buffered compare update and the rule that a set beats a clear.

// File: rtl/pwm_tc_pkg.sv
package pwm_tc_pkg;
  typedef enum logic [1:0] {
    OUT_OFF    = 2'b00,
    OUT_TOGGLE = 2'b01,
    OUT_NORM   = 2'b10,
    OUT_INV    = 2'b11
  } out_mode_e;

  localparam int SEL_W   = 3;
  localparam int NUM_CH  = 2;
endpackage

// File: rtl/pwm_tc_prescaler.sv
module pwm_tc_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] clk_sel,
  output logic       tick
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] mask;
  logic             run;

  always_comb begin
    run  = 1'b1;
    mask = '0;
    case (clk_sel)
      3'd1:    mask = '0;
      3'd2:    mask = PRE_W'(7);
      3'd3:    mask = PRE_W'(63);
      3'd4:    mask = PRE_W'(255);
      3'd5:    mask = PRE_W'(1023);
      default: run  = 1'b0;
    endcase
  end

  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else             div_q <= div_q + PRE_W'(1);
  end

  a_r2_stopped: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == 3'd0 || clk_sel > 3'd5) |-> !tick);
  a_r2_div_one: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == 3'd1) |-> tick);
  a_r2_div8_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && clk_sel == 3'd2 && $past(clk_sel) == 3'd2) |=> !tick);
endmodule

// File: rtl/pwm_tc_updown.sv
module pwm_tc_updown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_n,
  output logic             up_n
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  logic up_q;

  always_comb begin
    if (cnt_q == MAXV)     up_n = 1'b0;
    else if (cnt_q == '0)  up_n = 1'b1;
    else                   up_n = up_q;
    cnt_n = up_n ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick) begin
      cnt_q <= cnt_n;
      up_q  <= up_n;
    end
  end

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));
  a_r3_peak: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q == MAXV) |=> (cnt_q == MAXV - CNT_W'(1)) && !up_q);
  a_r3_floor: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q == '0) |=> (cnt_q == CNT_W'(1)) && up_q);
  a_r3_climb: assert property (@(posedge clk) disable iff (rst)
    (tick && up_q && cnt_q != MAXV) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/pwm_tc_channel.sv
module pwm_tc_channel
  import pwm_tc_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter bit HAS_TOG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_n,
  input  logic             up_n,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic [1:0]       mode,
  input  logic             tog_en,
  input  logic             clr_flag,
  output logic             pin_q,
  output logic             flag_q
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] ocr_q;
  logic [CNT_W-1:0] ocr_n;
  logic             hit;
  logic             level_q;
  logic             level_d;
  logic             tog_q;

  assign ocr_n = (cnt_n == MAXV) ? cmp_in : ocr_q;
  assign hit   = (cnt_n == ocr_n);

  always_comb begin
    level_d = level_q;
    if (ocr_n == '0)        level_d = 1'b0;
    else if (ocr_n == MAXV) level_d = 1'b1;
    else if (cnt_n == MAXV) level_d = 1'b0;
    else if (hit)           level_d = ~up_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ocr_q   <= '0;
      level_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (tick) begin
        level_q <= level_d;
        if (cnt_n == MAXV) ocr_q <= cmp_in;
      end
      if (tick && hit)   flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
    end
  end

  generate
    if (HAS_TOG) begin : g_tog
      always_ff @(posedge clk) begin
        if (rst)              tog_q <= 1'b0;
        else if (tick && hit) tog_q <= ~tog_q;
      end
      a_r8_flip: assert property (@(posedge clk) disable iff (rst)
        (tick && hit) |=> tog_q != $past(tog_q));
    end else begin : g_notog
      assign tog_q = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else begin
      case (out_mode_e'(mode))
        OUT_NORM:   pin_q <= level_q;
        OUT_INV:    pin_q <= ~level_q;
        OUT_TOGGLE: pin_q <= HAS_TOG && tog_en && tog_q;
        default:    pin_q <= 1'b0;
      endcase
    end
  end

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_flag) |=> flag_q);
  a_r10_set: assert property (@(posedge clk) disable iff (rst)
    (tick && hit) |=> flag_q);
  a_r5_top_high: assert property (@(posedge clk) disable iff (rst)
    (tick && ocr_n == MAXV) |=> level_q);
  a_r6_forced_low: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_n == MAXV && cmp_in != MAXV) |=> !level_q);
endmodule

// File: rtl/pwm_dual_slope_timer.sv
module pwm_dual_slope_timer
  import pwm_tc_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       clk_sel,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [1:0]       mode_a,
  input  logic [1:0]       mode_b,
  input  logic             tog_en_a,
  input  logic             clr_ovf,
  input  logic             clr_match_a,
  input  logic             clr_match_b,
  output logic             wave_a,
  output logic             wave_b,
  output logic             ovf_flag,
  output logic             match_a_flag,
  output logic             match_b_flag
);
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             up_n;

  logic [NUM_CH-1:0][CNT_W-1:0] cmp_arr;
  logic [NUM_CH-1:0][1:0]       mode_arr;
  logic [NUM_CH-1:0]            tog_arr;
  logic [NUM_CH-1:0]            clr_arr;
  logic [NUM_CH-1:0]            pin_arr;
  logic [NUM_CH-1:0]            flag_arr;

  assign cmp_arr  = {cmp_b, cmp_a};
  assign mode_arr = {mode_b, mode_a};
  assign tog_arr  = {1'b0, tog_en_a};
  assign clr_arr  = {clr_match_b, clr_match_a};

  pwm_tc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .tick(tick)
  );

  pwm_tc_updown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .cnt_q(cnt_q), .cnt_n(cnt_n), .up_n(up_n)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_tc_channel #(.CNT_W(CNT_W), .HAS_TOG(c == 0)) u_ch (
      .clk(clk), .rst(rst), .tick(tick),
      .cnt_n(cnt_n), .up_n(up_n),
      .cmp_in(cmp_arr[c]), .mode(mode_arr[c]), .tog_en(tog_arr[c]),
      .clr_flag(clr_arr[c]),
      .pin_q(pin_arr[c]), .flag_q(flag_arr[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                       ovf_flag <= 1'b0;
    else if (tick && cnt_n == '0)  ovf_flag <= 1'b1;
    else if (clr_ovf)              ovf_flag <= 1'b0;
  end

  assign wave_a       = pin_arr[0];
  assign wave_b       = pin_arr[1];
  assign match_a_flag = flag_arr[0];
  assign match_b_flag = flag_arr[1];

  a_r3_ovf_bottom: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q == CNT_W'(1) && !up_n) |=> ovf_flag);
  a_r9_off_a: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_a) == 2'b00) |-> !wave_a);
  a_r8_b_no_toggle: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_b) == 2'b01) |-> !wave_b);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !wave_a && !wave_b && !ovf_flag && !match_a_flag && !match_b_flag);
endmodule

// File: tb/pwm_dual_slope_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_dual_slope_timer_tb_top;
  localparam int TW = 4;
  localparam int PW = 10;
  localparam logic [TW-1:0] TMAX = '1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    clk_sel = 3'd1;
  logic [TW-1:0] cmp_a = '0, cmp_b = '0;
  logic [1:0]    mode_a = 2'b00, mode_b = 2'b00;
  logic          tog_en_a = 1'b0;
  logic          clr_ovf = 1'b0, clr_match_a = 1'b0, clr_match_b = 1'b0;
  logic          wave_a, wave_b, ovf_flag, match_a_flag, match_b_flag;

  int n_chk = 0;
  int n_err = 0;
  string cur_req = "R1";
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  pwm_dual_slope_timer #(.CNT_W(TW), .PRE_W(PW)) dut_i (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .mode_a(mode_a), .mode_b(mode_b), .tog_en_a(tog_en_a),
    .clr_ovf(clr_ovf), .clr_match_a(clr_match_a), .clr_match_b(clr_match_b),
    .wave_a(wave_a), .wave_b(wave_b), .ovf_flag(ovf_flag),
    .match_a_flag(match_a_flag), .match_b_flag(match_b_flag)
  );

  // arithmetic model built from the requirements
  logic [PW-1:0] m_pre;
  logic [TW-1:0] m_cnt;
  logic          m_up;
  logic [TW-1:0] m_ocr [2];
  logic          m_lvl [2];
  logic          m_tog;
  logic          m_flag [2];
  logic          m_ovf;
  logic          m_pin [2];

  function automatic logic pinsel(logic [1:0] md, logic lv, logic tg, logic ten);
    case (md)
      2'b10:   return lv;
      2'b11:   return !lv;
      2'b01:   return ten & tg;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pre = '0; m_cnt = '0; m_up = 1'b1; m_tog = 1'b0; m_ovf = 1'b0;
      for (int c = 0; c < 2; c++) begin
        m_ocr[c] = '0; m_lvl[c] = 1'b0; m_flag[c] = 1'b0; m_pin[c] = 1'b0;
      end
    end else begin
      logic          valid, tk, d, ov_set;
      logic [PW-1:0] mask;
      logic [TW-1:0] n;
      logic          set_f [2];
      m_pin[0] = pinsel(mode_a, m_lvl[0], m_tog, tog_en_a);
      m_pin[1] = pinsel(mode_b, m_lvl[1], 1'b0, 1'b0);
      valid = (clk_sel >= 3'd1 && clk_sel <= 3'd5);
      case (clk_sel)
        3'd2: mask = 7;  3'd3: mask = 63;  3'd4: mask = 255;  3'd5: mask = 1023;
        default: mask = 0;
      endcase
      tk = valid && ((m_pre & mask) == mask);
      m_pre = valid ? m_pre + 1'b1 : '0;
      ov_set = 1'b0; set_f[0] = 1'b0; set_f[1] = 1'b0;
      if (tk) begin
        d = (m_cnt == TMAX) ? 1'b0 : (m_cnt == 0) ? 1'b1 : m_up;
        n = d ? m_cnt + 1'b1 : m_cnt - 1'b1;
        for (int c = 0; c < 2; c++) begin
          logic [TW-1:0] cv, on;
          cv = (c == 0) ? cmp_a : cmp_b;
          on = (n == TMAX) ? cv : m_ocr[c];
          if (on == 0)             m_lvl[c] = 1'b0;
          else if (on == TMAX)     m_lvl[c] = 1'b1;
          else if (n == TMAX)      m_lvl[c] = 1'b0;
          else if (n == on)        m_lvl[c] = !d;
          if (n == on) begin
            set_f[c] = 1'b1;
            if (c == 0) m_tog = !m_tog;
          end
          if (n == TMAX) m_ocr[c] = cv;
        end
        ov_set = (n == 0);
        m_cnt = n; m_up = d;
      end
      m_ovf     = ov_set   ? 1'b1 : clr_ovf     ? 1'b0 : m_ovf;
      m_flag[0] = set_f[0] ? 1'b1 : clr_match_a ? 1'b0 : m_flag[0];
      m_flag[1] = set_f[1] ? 1'b1 : clr_match_b ? 1'b0 : m_flag[1];
    end
  end

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s at %0t: got %0b expected %0b", req, what, $time, got, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "wave_a", wave_a, m_pin[0]);
      chk(cur_req, "wave_b", wave_b, m_pin[1]);
      chk("R3", "ovf_flag", ovf_flag, m_ovf);
      chk("R10", "match_a_flag", match_a_flag, m_flag[0]);
      chk("R10", "match_b_flag", match_b_flag, m_flag[1]);
    end
  end

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic do_reset(input logic [2:0] sel);
    @(negedge clk);
    rst = 1'b1; clk_sel = sel;
    clr_ovf = 1'b0; clr_match_a = 1'b0; clr_match_b = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sweep(input logic [1:0] ma, input logic [1:0] mb, input logic ten,
                       input string req);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      cmp_a = TW'(v); cmp_b = TW'(15 - v);
      mode_a = ma; mode_b = mb; tog_en_a = ten;
      cur_req = (req == "R4" && (v == 0 || v == 15)) ? "R5" : req;
      repeat (64) @(negedge clk);
    end
  endtask

  task automatic run_rand(input int cycles, input logic [2:0] sel, input string req);
    @(negedge clk);
    clk_sel = sel; cur_req = req;
    for (int i = 0; i < cycles; i++) begin
      step_lfsr();
      clr_ovf     = (lfsr[2:0] == 3'd0);
      clr_match_a = (lfsr[5:3] == 3'd1);
      clr_match_b = (lfsr[8:6] == 3'd2);
      if (i % 23 == 0) begin
        cmp_a    = lfsr[TW+8:9];
        cmp_b    = lfsr[TW+3:4] ^ lfsr[15:12];
        mode_a   = lfsr[11:10];
        mode_b   = lfsr[14:13];
        tog_en_a = lfsr[15];
      end
      @(negedge clk);
    end
    clr_ovf = 1'b0; clr_match_a = 1'b0; clr_match_b = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int waited;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "wave_a in reset", wave_a, 1'b0);
    chk("R1", "wave_b in reset", wave_b, 1'b0);
    chk("R1", "ovf in reset", ovf_flag, 1'b0);
    chk("R1", "match_a in reset", match_a_flag, 1'b0);
    chk("R1", "match_b in reset", match_b_flag, 1'b0);

    // R2 and R3: first overflow with /8 lands after 30 ticks * 8 clocks
    do_reset(3'd2);
    cur_req = "R2";
    waited = 0;
    while (!ovf_flag && waited < 1000) begin
      @(negedge clk);
      waited++;
    end
    n_chk++;
    if (waited != 240) begin
      n_err++;
      $display("FAIL R2 R3 first ovf delay: got %0d expected %0d", waited, 240);
    end

    // R4/R5: every compare value, normal on A, inverted on B
    do_reset(3'd1);
    sweep(2'b10, 2'b11, 1'b0, "R4");
    // R8: toggle on A, B in mode 01 stays low
    sweep(2'b01, 2'b01, 1'b1, "R8");
    // R8: toggle mode without enable stays low
    sweep(2'b01, 2'b10, 1'b0, "R8");
    // R9: disconnected pins
    sweep(2'b00, 2'b00, 1'b0, "R9");

    // R6: compare leaves MAX, forced transition at the top
    @(negedge clk);
    cur_req = "R6"; mode_a = 2'b10; mode_b = 2'b11; cmp_a = TMAX; cmp_b = TMAX;
    repeat (45) @(negedge clk);
    cmp_a = 4'd5; cmp_b = 4'd9;
    repeat (70) @(negedge clk);

    // R6/R7/R10: random changes mid period with clear strobes
    run_rand(4000, 3'd1, "R6/R7");
    // R2: other prescale settings, including stopped codes
    run_rand(4000, 3'd3, "R2");
    run_rand(300, 3'd0, "R2");
    run_rand(16000, 3'd4, "R2");
    run_rand(300, 3'd6, "R2");
    run_rand(32000, 3'd5, "R2");
    run_rand(300, 3'd7, "R2");
    run_rand(600, 3'd2, "R2");

    finish_run();
  end
endmodule